// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

This block moves data between two 18-bit ports, A and B, in both directions at once. Each direction has its own storage element and its own three controls: an output enable, a latch enable and a direction clock. With the latch enable high, the output follows the opposite port's input. With it low, the stored word is held, and a falling edge of the direction clock loads a new word. The enable of the A-to-B path is active high. The enable of the B-to-A path is active low.

The block runs on one fast system clock. The latch enables and the two direction clocks are sampled as ordinary signals. A falling edge of a direction clock is found by comparing its current level with the level sampled on the previous system edge. Each port is presented as three signals: an input bus, an output bus and an output-enable flag. A disabled output bus carries all zeros.

Top module: `ubt_bidir_xcvr`

## Requirements
- R1: The two directions are independent. Any activity on the A-to-B controls or on `a_in` leaves `a_out` unchanged, and any activity on the B-to-A controls or on `b_in` leaves `b_out` unchanged.
- R2: While `ab_le` is 1 and `ab_oe` is 1, `b_out` equals `a_in` within the same cycle.
- R3: While `ab_le` is 0 and no falling edge of `ab_clk` is detected, the stored A-to-B word does not change, whatever `a_in` does.
- R4: While `ab_le` is 0, a falling edge of `ab_clk` loads `a_in` as sampled on the system edge that sees `ab_clk` low. A falling edge means 1 on the previous system edge and 0 on this one. The new word is on `b_out` after that system edge.
- R5: A rising edge of `ab_clk`, or `ab_clk` held high, loads nothing.
- R6: When `ab_le` goes from 1 to 0, `b_out` keeps the value `a_in` had on the last system edge at which `ab_le` was 1.
- R7: If `ab_le` is 1 in a cycle where a falling edge of `ab_clk` is detected, `b_out` shows the current `a_in`, and that word is the one stored.
- R8: `b_oe` equals `ab_oe`. While `ab_oe` is 0, `b_out` is all zeros.
- R9: `a_oe` equals the inverse of `ba_oe_n`. While `ba_oe_n` is 1, `a_out` is all zeros.
- R10: A synchronous active-high `rst` clears both stored words to zero. During reset the output-enable flags still follow `ab_oe` and `ba_oe_n`.
- R11: The B-to-A path works like the A-to-B path, using `ba_le`, `ba_clk`, `b_in` and `a_out`: it has the same transparent, hold and falling-edge capture behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of both stored words |
| a_in | input | 18 | Data arriving at port A |
| a_out | output | 18 | Data driven onto port A; zero when disabled |
| a_oe | output | 1 | Port A drive flag |
| b_in | input | 18 | Data arriving at port B |
| b_out | output | 18 | Data driven onto port B; zero when disabled |
| b_oe | output | 1 | Port B drive flag |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable; 1 makes the path transparent |
| ab_clk | input | 1 | A-to-B direction clock; loads on its falling edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable; 1 makes the path transparent |
| ba_clk | input | 1 | B-to-A direction clock; loads on its falling edge |

## Verification
Transparent data and the enable gating are combinational, so the bench checks them 1 ns after it changes an input, before the next system edge. A capture, a latch closure or a reset takes effect on the first system rising edge after the stimulus is applied. The bench drives its inputs 4 ns after a rising edge and checks these results 4 ns after the following rising edge. Where the bench checks that nothing loads, such as on a rising direction-clock edge, it waits one or more edges and then confirms that the old word is still on the output.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    // What a direction's storage does on the coming system edge.
    typedef enum logic [1:0] {
        LANE_HOLD    = 2'd0,
        LANE_FOLLOW  = 2'd1,
        LANE_CAPTURE = 2'd2
    } lane_act_e;

    // The open latch wins over a detected falling edge.
    function automatic lane_act_e lane_pick(input logic le, input logic fall);
        if (le) begin
            return LANE_FOLLOW;
        end else if (fall) begin
            return LANE_CAPTURE;
        end
        return LANE_HOLD;
    endfunction

endpackage

// File: rtl/ubt_fall_det.sv
module ubt_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic fall
);
    logic prev_d;
    logic prev_q;

    always_comb begin
        prev_d = rst ? 1'b0 : level;
        fall   = prev_q & ~level;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane
    import ubt_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    input  logic             le,
    input  logic             dclk,
    output logic [WIDTH-1:0] view
);
    localparam logic [WIDTH-1:0] CLEAR = '0;

    typedef struct packed {
        logic [WIDTH-1:0] held;
    } lane_state_t;

    lane_state_t state_d;
    lane_state_t state_q;
    lane_act_e   act;
    logic        fall;

    ubt_fall_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (dclk),
        .fall  (fall)
    );

    always_comb begin
        state_d = state_q;
        act     = lane_pick(le, fall);
        unique case (act)
            LANE_FOLLOW, LANE_CAPTURE: state_d.held = din;
            default:                   state_d.held = state_q.held;
        endcase
        if (rst) begin
            state_d.held = CLEAR;
        end
        view = le ? din : state_q.held;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end
endmodule

// File: rtl/ubt_port_gate.sv
module ubt_port_gate #(
    parameter int WIDTH       = 18,
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic [WIDTH-1:0] data,
    input  logic             en_pin,
    output logic [WIDTH-1:0] bus,
    output logic             drive
);
    logic en;

    generate
        if (ACTIVE_HIGH) begin : g_hi
            assign en = en_pin;
        end else begin : g_lo
            assign en = ~en_pin;
        end
    endgenerate

    always_comb begin
        drive = en;
        bus   = en ? data : '0;
    end
endmodule

// File: rtl/ubt_bidir_xcvr.sv
module ubt_bidir_xcvr #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             ab_oe,
    input  logic             ab_le,
    input  logic             ab_clk,
    input  logic             ba_oe_n,
    input  logic             ba_le,
    input  logic             ba_clk
);
    logic [WIDTH-1:0] ab_view;
    logic [WIDTH-1:0] ba_view;

    // A to B
    ubt_lane #(.WIDTH(WIDTH)) u_lane_ab (
        .clk  (clk),
        .rst  (rst),
        .din  (a_in),
        .le   (ab_le),
        .dclk (ab_clk),
        .view (ab_view)
    );

    ubt_port_gate #(.WIDTH(WIDTH), .ACTIVE_HIGH(1'b1)) u_gate_b (
        .data   (ab_view),
        .en_pin (ab_oe),
        .bus    (b_out),
        .drive  (b_oe)
    );

    // B to A, enable of opposite polarity
    ubt_lane #(.WIDTH(WIDTH)) u_lane_ba (
        .clk  (clk),
        .rst  (rst),
        .din  (b_in),
        .le   (ba_le),
        .dclk (ba_clk),
        .view (ba_view)
    );

    ubt_port_gate #(.WIDTH(WIDTH), .ACTIVE_HIGH(1'b0)) u_gate_a (
        .data   (ba_view),
        .en_pin (ba_oe_n),
        .bus    (a_out),
        .drive  (a_oe)
    );
endmodule

// File: rtl/ubt_bidir_xcvr_chk.sv
module ubt_bidir_xcvr_chk #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             ab_oe,
    input logic             ab_le,
    input logic             ab_clk,
    input logic             ba_oe_n,
    input logic             ba_le,
    input logic             ba_clk
);
    assert_b_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (ab_le && ab_oe) |-> (b_out == a_in));

    assert_ab_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && ab_oe && !(!$past(rst) && $past(ab_clk) && !ab_clk))
        |=> (ab_le || !ab_oe || $stable(b_out)));

    assert_ab_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && !$past(rst) && $past(ab_clk) && !ab_clk)
        |=> (ab_le || !ab_oe || b_out == $past(a_in)));

    assert_ab_close_R6: assert property (@(posedge clk) disable iff (rst)
        ab_le |=> (ab_le || !ab_oe || b_out == $past(a_in)));

    assert_b_gated_R8: assert property (@(posedge clk) disable iff (rst)
        !ab_oe |-> (!b_oe && b_out == '0));

    assert_a_gated_R9: assert property (@(posedge clk) disable iff (rst)
        ba_oe_n |-> (!a_oe && a_out == '0));

    assert_clear_R10: assert property (@(posedge clk)
        rst |=> ((ab_le || !ab_oe || b_out == '0) && (ba_le || ba_oe_n || a_out == '0)));

    assert_a_follows_R11: assert property (@(posedge clk) disable iff (rst)
        (ba_le && !ba_oe_n) |-> (a_out == b_in));

    assert_ba_capture_R11: assert property (@(posedge clk) disable iff (rst)
        (!ba_le && !$past(rst) && $past(ba_clk) && !ba_clk)
        |=> (ba_le || ba_oe_n || a_out == $past(b_in)));
endmodule

bind ubt_bidir_xcvr ubt_bidir_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_ubt_bidir_xcvr.sv
module tb_ubt_bidir_xcvr;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe;
    logic         ab_oe, ab_le, ab_clk, ba_oe_n, ba_le, ba_clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ubt_bidir_xcvr #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #4;
    endtask

    task automatic t_reset;
        rst = 1'b1; ab_oe = 1'b1; ba_oe_n = 1'b0;
        ab_le = 1'b0; ba_le = 1'b0; ab_clk = 1'b0; ba_clk = 1'b0;
        a_in = 18'h2A5A5; b_in = 18'h15A5A;
        tick; tick;
        chk("R10 b_oe in reset", {17'd0, b_oe}, 18'd1);
        ab_oe = 1'b0; #1;
        chk("R10 b_oe follows in reset", {17'd0, b_oe}, 18'd0);
        ab_oe = 1'b1;
        rst = 1'b0;
        tick;
        chk("R10 b_out cleared", b_out, '0);
        chk("R10 a_out cleared", a_out, '0);
    endtask

    task automatic t_ab_transparent;
        ab_le = 1'b1; a_in = 18'h0F0F0; #1;
        chk("R2 follow 1", b_out, 18'h0F0F0);
        a_in = 18'h30C3C; #1;
        chk("R2 follow 2", b_out, 18'h30C3C);
        tick;
        chk("R2 follow after edge", b_out, 18'h30C3C);
    endtask

    task automatic t_ab_close;
        a_in = 18'h1E1E1; tick;
        ab_le = 1'b0; a_in = 18'h21E1E; #1;
        chk("R6 close keeps last", b_out, 18'h1E1E1);
        tick;
        chk("R3 hold after close", b_out, 18'h1E1E1);
    endtask

    task automatic t_ab_capture;
        ab_clk = 1'b1; a_in = 18'h00001; tick;
        chk("R5 rising no load", b_out, 18'h1E1E1);
        ab_clk = 1'b0; #1;
        chk("R4 not before edge", b_out, 18'h1E1E1);
        tick;
        a_in = 18'h3FFFF; #1;
        chk("R4 captured on fall", b_out, 18'h00001);
        for (int i = 0; i < 3; i++) begin
            a_in = 18'h20000 >> i; tick;
        end
        chk("R3 steady low holds", b_out, 18'h00001);
        ab_clk = 1'b1; a_in = 18'h12345; tick; tick;
        chk("R5 high holds", b_out, 18'h00001);
        ab_clk = 1'b0; tick;
        chk("R4 second fall", b_out, 18'h12345);
    endtask

    task automatic t_ab_priority;
        ab_clk = 1'b1; tick;
        ab_clk = 1'b0; ab_le = 1'b1; a_in = 18'h2AAAA; #1;
        chk("R7 transparent wins", b_out, 18'h2AAAA);
        tick;
        ab_le = 1'b0; a_in = 18'h15555; #1;
        chk("R7 stored current", b_out, 18'h2AAAA);
    endtask

    task automatic t_ab_enable;
        ab_oe = 1'b0; #1;
        chk("R8 b_oe low", {17'd0, b_oe}, 18'd0);
        chk("R8 b_out zero", b_out, '0);
        ab_le = 1'b1; a_in = 18'h0ABCD; #1;
        chk("R8 zero when open", b_out, '0);
        ab_oe = 1'b1; #1;
        chk("R8 drives again", b_out, 18'h0ABCD);
        chk("R8 b_oe high", {17'd0, b_oe}, 18'd1);
        tick;
        ab_le = 1'b0;
    endtask

    task automatic t_ba_paths;
        logic [W-1:0] b_seen;
        b_seen = b_out;
        ba_le = 1'b1; b_in = 18'h33333; #1;
        chk("R11 a follows b", a_out, 18'h33333);
        tick;
        ba_le = 1'b0; ba_clk = 1'b1; b_in = 18'h0C0C0; tick;
        chk("R11 rising no load", a_out, 18'h33333);
        ba_clk = 1'b0; tick;
        b_in = 18'h3F000; #1;
        chk("R11 fall capture", a_out, 18'h0C0C0);
        tick;
        chk("R11 hold", a_out, 18'h0C0C0);
        chk("R1 b_out untouched", b_out, b_seen);
        ba_oe_n = 1'b1; #1;
        chk("R9 a_oe low", {17'd0, a_oe}, 18'd0);
        chk("R9 a_out zero", a_out, '0);
        ba_oe_n = 1'b0; #1;
        chk("R9 a_oe high", {17'd0, a_oe}, 18'd1);
    endtask

    task automatic t_independence;
        logic [W-1:0] a_seen;
        a_seen = a_out;
        ab_clk = 1'b1; a_in = 18'h05050; tick;
        ab_clk = 1'b0; tick;
        ab_le = 1'b1; a_in = 18'h3A3A3; tick;
        ab_le = 1'b0; tick;
        chk("R1 a_out untouched", a_out, a_seen);
        chk("R2 ab path still works", b_out, 18'h3A3A3);
    endtask

    task automatic t_reset_again;
        rst = 1'b1; tick;
        rst = 1'b0; #1;
        chk("R10 b cleared after use", b_out, '0);
        chk("R10 a cleared after use", a_out, '0);
    endtask

    initial begin
        t_reset;
        t_ab_transparent;
        t_ab_close;
        t_ab_capture;
        t_ab_priority;
        t_ab_enable;
        t_ba_paths;
        t_independence;
        t_reset_again;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule